// File: doc/BRIEF.md
# Seconds Countdown Alarm with Wakeup Gating

This block counts down a software-loaded interval, one step per one-second tick, and flags the moment the count runs out. Software reaches it through a simple register bus. A write to the interval register loads the interval and also copies it into the live counter. A separate run enable lets the count advance. When the count reaches zero, a sticky status flag is raised. Software clears that flag by writing a one to it.

Two outputs are derived from the status flag, and each has its own gate. The interrupt line needs the interrupt enable. The wakeup line needs the wakeup enable. The flag itself is raised whatever either enable holds, so software can poll it with both outputs masked.

A second, weekly alarm has only placeholder registers. Its enables can be written and read back. Its status bit always reads zero and never drives either output.

Top module: `countdown_alarm`

## Requirements
- R1: After reset every register reads 0, and both `irqOut` and `wakeOut` are low.
- R2: A write to the interval register (offset 0x20) stores the value, and that offset reads it back. The same write copies the value into the live counter, which reads at offset 0x24 from the next cycle.
- R3: The counter decrements by one on a cycle where `tickSec` is high, the run enable (bit 0 at offset 0x28) is set and the counter is nonzero. In any other cycle it holds its value.
- R4: When a tick takes the counter from 1 to 0, the status flag (bit 0 at offset 0x30) is set in the same edge, even while the interrupt enable is clear.
- R5: `irqOut` is high exactly when the status flag and the interrupt enable (bit 0 at offset 0x2C) are both set.
- R6: `wakeOut` is high exactly when the status flag and the wakeup enable (bit 0 at offset 0x50) are both set.
- R7: Writing 1 to bit 0 of offset 0x30 clears the status flag. Writing 0 there leaves the flag unchanged.
- R8: Loading 0 stops a running count at once, and the status flag is not set by it or by any later tick.
- R9: If an interval write and an enabled tick land in the same cycle, the counter takes the written value with no decrement.
- R10: Once the counter sits at 0, further ticks leave it at 0 and do not set the status flag again.
- R11: If an expiry and a clear of the status flag land in the same cycle, the flag ends up set.
- R12: The weekly placeholders behave as follows. Bit 0 of offsets 0x44 and 0x48 is writable and reads back. Offset 0x4C always reads 0 and accepts a write-one without effect. None of the three changes `irqOut` or `wakeOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for `busAddr` (combinational) |
| tickSec | input | 1 | One-cycle pulse per second |
| irqOut | output | 1 | Interrupt request |
| wakeOut | output | 1 | Wakeup request |

## Verification
The bench builds the block with its default parameters: an 8-bit address and a 32-bit data path and counter. That width lets the bench load the all-ones interval and watch the counter step down from the top of its range. Because the tick is a plain input, the bench drives it on its own. This brings the same-cycle collisions within reach: an interval write meeting a tick, and an expiry meeting a clear of the status flag.

// File: rtl/cda_pkg.sv
package cda_pkg;
  localparam int unsigned OFF_LOAD   = 'h20;
  localparam int unsigned OFF_CUR    = 'h24;
  localparam int unsigned OFF_RUN    = 'h28;
  localparam int unsigned OFF_IRQEN  = 'h2C;
  localparam int unsigned OFF_PEND   = 'h30;
  localparam int unsigned OFF_WKEN   = 'h44;
  localparam int unsigned OFF_WKIRQ  = 'h48;
  localparam int unsigned OFF_WKPEND = 'h4C;
  localparam int unsigned OFF_WAKE   = 'h50;

  typedef struct packed {
    logic loadStb;   // interval write this cycle
    logic clrStb;    // write-one to status bit
    logic tickGo;    // enabled tick this cycle
  } cdaStrobes_t;
endpackage

// File: rtl/cda_datapath.sv
module cda_datapath
  import cda_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  cdaStrobes_t       strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] cntVal,
  output logic              pending
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic cntNonZero;
  logic expireNow;

  assign cntNonZero = |cntVal;
  // a load wins over a tick, so no expiry may come from the same cycle
  assign expireNow  = strb.tickGo && !strb.loadStb && (cntVal == ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadVal <= '0;
      cntVal  <= '0;
    end else if (strb.loadStb) begin
      loadVal <= wrData;
      cntVal  <= wrData;
    end else if (strb.tickGo && cntNonZero) begin
      cntVal  <= cntVal - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              pending <= 1'b0;
    else if (expireNow)     pending <= 1'b1;
    else if (strb.clrStb)   pending <= 1'b0;
  end
endmodule

// File: rtl/cda_ctrl.sv
module cda_ctrl
  import cda_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              tickSec,
  input  logic [DATA_W-1:0] loadVal,
  input  logic [DATA_W-1:0] cntVal,
  input  logic              pending,
  output cdaStrobes_t       strb,
  output logic [DATA_W-1:0] busRdata,
  output logic              cntEn,
  output logic              irqEn,
  output logic              wakeEn
);
  localparam logic [DATA_W-1:0] ZERO_PAD = '0;

  logic wrAcc;
  logic wkEn;
  logic wkIrqEn;

  assign wrAcc = busSel && busWrite;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  always_comb begin
    strb         = '0;
    strb.loadStb = wrAcc && hit(busAddr, OFF_LOAD);
    strb.clrStb  = wrAcc && hit(busAddr, OFF_PEND) && busWdata[0];
    strb.tickGo  = tickSec && cntEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntEn   <= 1'b0;
      irqEn   <= 1'b0;
      wakeEn  <= 1'b0;
      wkEn    <= 1'b0;
      wkIrqEn <= 1'b0;
    end else if (wrAcc) begin
      if (hit(busAddr, OFF_RUN))   cntEn   <= busWdata[0];
      if (hit(busAddr, OFF_IRQEN)) irqEn   <= busWdata[0];
      if (hit(busAddr, OFF_WAKE))  wakeEn  <= busWdata[0];
      if (hit(busAddr, OFF_WKEN))  wkEn    <= busWdata[0];
      if (hit(busAddr, OFF_WKIRQ)) wkIrqEn <= busWdata[0];
    end
  end

  always_comb begin
    busRdata = ZERO_PAD;
    if      (hit(busAddr, OFF_LOAD))  busRdata = loadVal;
    else if (hit(busAddr, OFF_CUR))   busRdata = cntVal;
    else if (hit(busAddr, OFF_RUN))   busRdata[0] = cntEn;
    else if (hit(busAddr, OFF_IRQEN)) busRdata[0] = irqEn;
    else if (hit(busAddr, OFF_PEND))  busRdata[0] = pending;
    else if (hit(busAddr, OFF_WAKE))  busRdata[0] = wakeEn;
    else if (hit(busAddr, OFF_WKEN))  busRdata[0] = wkEn;
    else if (hit(busAddr, OFF_WKIRQ)) busRdata[0] = wkIrqEn;
  end
endmodule

// File: rtl/countdown_alarm.sv
module countdown_alarm
  import cda_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tickSec,
  output logic              irqOut,
  output logic              wakeOut
);
  cdaStrobes_t       strb;
  logic [DATA_W-1:0] loadVal;
  logic [DATA_W-1:0] cntVal;
  logic              pending;
  logic              cntEn;
  logic              irqEn;
  logic              wakeEn;

  cda_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .tickSec  (tickSec),
    .loadVal  (loadVal),
    .cntVal   (cntVal),
    .pending  (pending),
    .strb     (strb),
    .busRdata (busRdata),
    .cntEn    (cntEn),
    .irqEn    (irqEn),
    .wakeEn   (wakeEn)
  );

  cda_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (busWdata),
    .loadVal (loadVal),
    .cntVal  (cntVal),
    .pending (pending)
  );

  assign irqOut  = pending & irqEn;
  assign wakeOut = pending & wakeEn;
endmodule

// File: rtl/cda_checker.sv
module cda_checker
  import cda_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              tickSec,
  input logic [DATA_W-1:0] cntVal,
  input logic              pending,
  input logic              cntEn,
  input logic              irqEn,
  input logic              wakeEn,
  input logic              irqOut,
  input logic              wakeOut
);
  logic loadW, clrW, stepOk;
  assign loadW  = busSel && busWrite && (busAddr == ADDR_W'(OFF_LOAD));
  assign clrW   = busSel && busWrite && (busAddr == ADDR_W'(OFF_PEND)) && busWdata[0];
  assign stepOk = tickSec && cntEn && !loadW;

  p_load_copy_r2: assert property (@(posedge clk) disable iff (!rstN)
    loadW |=> cntVal == $past(busWdata));

  p_dec_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stepOk && cntVal != '0) |=> cntVal == $past(cntVal) - DATA_W'(1));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!loadW && !(tickSec && cntEn)) |=> $stable(cntVal));

  p_expire_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stepOk && cntVal == DATA_W'(1)) |=> pending);

  p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (pending && irqEn));

  p_wake_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> (pending && wakeEn));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (clrW && !(stepOk && cntVal == DATA_W'(1))) |=> !pending);

  p_zero_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (loadW && busWdata == '0 && !pending) |=> !pending);

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal == '0 && !loadW && !pending) |=> (cntVal == '0 && !pending));
endmodule

bind countdown_alarm cda_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .tickSec  (tickSec),
  .cntVal   (cntVal),
  .pending  (pending),
  .cntEn    (cntEn),
  .irqEn    (irqEn),
  .wakeEn   (wakeEn),
  .irqOut   (irqOut),
  .wakeOut  (wakeOut)
);

// File: tb/test_countdown_alarm.sv
module test_countdown_alarm;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busSel = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic              tickSec = 1'b0;
  logic              irqOut;
  logic              wakeOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] exp;
    string             tag;
  } rdItem_t;
  rdItem_t expQ[$];

  always #10 clk = ~clk;

  countdown_alarm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_countdown_alarm (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tickSec(tickSec), .irqOut(irqOut), .wakeOut(wakeOut)
  );

  // monitor: pops one expected item per read cycle, mid-cycle
  always @(negedge clk) begin
    if (busSel && !busWrite && expQ.size() > 0) begin
      rdItem_t it;
      it = expQ.pop_front();
      checks++;
      if (busRdata !== it.exp) begin
        errors++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, busRdata, it.exp);
      end
    end
  end

  task automatic busWr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input bit withTick = 1'b0);
    @(posedge clk); #1;
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d; tickSec = withTick;
    @(posedge clk); #1;
    busSel = 1'b0; busWrite = 1'b0; tickSec = 1'b0;
  endtask

  task automatic busRd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
    rdItem_t it;
    @(posedge clk); #1;
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    expQ.push_back(it);
    @(posedge clk); #1;
    busSel = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; tickSec = 1'b1;
      @(posedge clk); #1; tickSec = 1'b0;
    end
  endtask

  task automatic pinChk(input logic act, input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, e);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    busRd(8'h20, 0, "R1 load"); busRd(8'h24, 0, "R1 cur"); busRd(8'h28, 0, "R1 run");
    busRd(8'h2C, 0, "R1 irqen"); busRd(8'h30, 0, "R1 pend"); busRd(8'h50, 0, "R1 wake");
    pinChk(irqOut, 1'b0, "R1 irqOut"); pinChk(wakeOut, 1'b0, "R1 wakeOut");
    // R2 load and copy
    busWr(8'h20, 5);
    busRd(8'h20, 5, "R2 load readback"); busRd(8'h24, 5, "R2 counter copy");
    // R3 held while disabled
    ticks(3); busRd(8'h24, 5, "R3 disabled hold");
    busWr(8'h28, 1);
    ticks(2); busRd(8'h24, 3, "R3 two steps");
    repeat (5) @(posedge clk);
    busRd(8'h24, 3, "R3 no tick hold");
    // R4 expiry with interrupt masked
    ticks(3); busRd(8'h24, 0, "R4 counter zero"); busRd(8'h30, 1, "R4 pending set");
    pinChk(irqOut, 1'b0, "R4 irq masked");
    // R10 idle at zero
    ticks(2); busRd(8'h24, 0, "R10 stays zero");
    // R7 write 0 keeps flag
    busWr(8'h30, 0); busRd(8'h30, 1, "R7 write zero no effect");
    // R5, R6 gating
    busWr(8'h2C, 1); pinChk(irqOut, 1'b1, "R5 irq on");
    pinChk(wakeOut, 1'b0, "R6 wake masked");
    busWr(8'h50, 1); pinChk(wakeOut, 1'b1, "R6 wake on");
    busWr(8'h2C, 0); pinChk(irqOut, 1'b0, "R5 irq off");
    // R7 clear
    busWr(8'h30, 1); busRd(8'h30, 0, "R7 cleared");
    pinChk(wakeOut, 1'b0, "R7 wake drops");
    ticks(2); busRd(8'h30, 0, "R10 no re-set");
    // R8 zero load and stop
    busWr(8'h20, 0); ticks(2); busRd(8'h30, 0, "R8 zero load");
    busWr(8'h20, 3); ticks(1); busRd(8'h24, 2, "R8 running");
    busWr(8'h20, 0); busRd(8'h24, 0, "R8 stopped");
    ticks(4); busRd(8'h30, 0, "R8 never pends");
    // R9 load beats tick
    busWr(8'h20, 7, 1'b1); busRd(8'h24, 7, "R9 load wins");
    // full-width count
    busWr(8'h20, 32'hFFFF_FFFF); ticks(1); busRd(8'h24, 32'hFFFF_FFFE, "R3 top of range");
    // R11 set beats clear
    busWr(8'h20, 1);
    @(posedge clk); #1;
    busSel = 1'b1; busWrite = 1'b1; busAddr = 8'h30; busWdata = 1; tickSec = 1'b1;
    @(posedge clk); #1;
    busSel = 1'b0; busWrite = 1'b0; tickSec = 1'b0;
    busRd(8'h30, 1, "R11 set wins");
    pinChk(wakeOut, 1'b1, "R11 wake");
    busWr(8'h30, 1);
    // R12 weekly placeholders
    busWr(8'h44, 1); busWr(8'h48, 1); busWr(8'h4C, 1);
    busRd(8'h44, 1, "R12 wk enable"); busRd(8'h48, 1, "R12 wk irq enable");
    busRd(8'h4C, 0, "R12 wk status");
    pinChk(irqOut, 1'b0, "R12 irq unaffected"); pinChk(wakeOut, 1'b0, "R12 wake unaffected");
    repeat (3) @(posedge clk);
    summary();
  end
endmodule